// File: doc/BRIEF.md
# Segmented Carry-Deferred Stream Accumulator

This block sums a long stream of signed operands, such as the products feeding one output of a neural-network dot product, where only the total at the end of the stream is used. The wide addition is a ripple-carry adder cut into a lower and an upper segment. The only register at the cut is one carry flip-flop. The lower segment's carry-out is captured there and added into the upper segment one cycle later. No full rank of pipeline registers is placed across the adder.

A stream begins with a clear pulse. Operands then arrive with a valid strobe, and the final operand is flagged. Each operand is sign-extended to the accumulator width and held in an input buffer register for one cycle before it is added. While the stream runs, the visible sum can be short by one deferred carry. After the final operand, one zero-operand flush cycle absorbs the pending carry. The done flag then rises, and the sum stays frozen until the next clear.

Top module: `seg_accum`

## Requirements
- R1: While reset is high and after it is released, `sum_out` reads zero and `done` reads 0 until a stream completes.
- R2: Each `in_data` value is treated as a two's-complement number of width IN_W and sign-extended to ACC_W bits before it is added.
- R3: When `done` is 1, `sum_out` equals the sum of all accepted operands of the stream, modulo 2^ACC_W, and no carry is left pending at the segment cut.
- R4: If the final operand (`in_valid` and `in_last` both 1) is sampled at clock edge k, `done` is 0 after edges k and k+1 and is 1 after edge k+2.
- R5: A carry out of the lower LO_W bits at edge j is added into the upper segment at edge j+1. With the default split, operands -1 then +1 therefore show 0xFFFF0000 on `sum_out` for one cycle before the flush corrects it to 0.
- R6: A `clr` sampled at an edge zeroes the sum, the pending carry and the input buffer, and drops `done` after that edge. A carry left by an unfinished stream does not leak into the next stream.
- R7: While `done` is 1 and `clr` is 0, `in_valid` is ignored, and `sum_out` and `done` hold their values.
- R8: Idle cycles with `in_valid` low between operands do not change the final sum.
- R9: A 27-bit build (16-bit input, 11 guard bits, default split) gives the correct sum modulo 2^27, including across wrap-around.
- R10: An operand presented in the same cycle as `clr` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Starts a new stream: zeroes sum, carry and buffer |
| in_valid | input | 1 | Operand strobe |
| in_last | input | 1 | Marks the final operand of the stream |
| in_data | input | IN_W | Signed operand |
| sum_out | output | ACC_W | Accumulator register |
| done | output | 1 | Final sum is valid and frozen |

## Verification
Small positive streams set the baseline, and negative operands separate correct sign extension from zero extension. A -1/+1 pair forces a carry across the cut, so the bench can see the one-cycle deferral in the middle of the stream and then its correction by the flush. Streams with idle gaps, a clear that lands on a pending carry, and an operand that arrives together with a clear show that the carry flop and the buffer start each stream clean. A long pseudo-random stream wraps the 27-bit build, which shows that the modulo behaviour holds for a split point that is not a power of two.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Controller phases of one stream
    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,   // accepting operands
        ST_DRAIN = 2'd1,   // last operand sits in the input buffer
        ST_FLUSH = 2'd2,   // zero operand absorbs the deferred carry
        ST_HOLD  = 2'd3    // sum final and frozen
    } acc_phase_e;

    // Default position of the segment cut
    function automatic int split_point(input int width);
        return width / 2;
    endfunction

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic in_valid,
    input  logic in_last,
    output logic accept,
    output logic done
);

    acc_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= ST_ACCUM;
        end else begin
            unique case (phase_q)
                ST_ACCUM: if (in_valid && in_last) phase_q <= ST_DRAIN;
                ST_DRAIN: phase_q <= ST_FLUSH;
                ST_FLUSH: phase_q <= ST_HOLD;
                ST_HOLD:  phase_q <= ST_HOLD;
                default:  phase_q <= ST_ACCUM;
            endcase
        end
    end

    assign accept = (phase_q == ST_ACCUM) && in_valid && !clr;
    assign done   = (phase_q == ST_HOLD);

    // R4: done follows the final operand after exactly two more edges
    assert_done_delay_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_ACCUM && in_valid && in_last && !clr) ##1 !clr ##1 !clr |=> done);

endmodule

// File: rtl/acc_in_buf.sv
module acc_in_buf #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             accept,
    input  logic [IN_W-1:0]  in_data,
    output logic [ACC_W-1:0] op_q
);

    localparam int EXT_W = ACC_W - IN_W;

    logic [ACC_W-1:0] widened;

    generate
        if (EXT_W > 0) begin : g_ext
            assign widened = {{EXT_W{in_data[IN_W-1]}}, in_data};
        end else begin : g_same
            assign widened = in_data;
        end
    endgenerate

    // The buffer holds an operand for one cycle, otherwise zero
    always_ff @(posedge clk) begin
        if (rst || clr)  op_q <= '0;
        else if (accept) op_q <= widened;
        else             op_q <= '0;
    end

endmodule

// File: rtl/acc_lo_seg.sv
module acc_lo_seg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] sum_q,
    output logic         carry_q
);

    logic [W:0] wide;

    assign wide = {1'b0, sum_q} + {1'b0, opnd};

    // Lower slice plus the single carry flop at the cut
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else if (!hold) begin
            sum_q   <= wide[W-1:0];
            carry_q <= wide[W];
        end
    end

endmodule

// File: rtl/acc_hi_seg.sv
module acc_hi_seg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] opnd,
    input  logic         cin,
    output logic [W-1:0] sum_q
);

    // Upper slice adds its operand bits and last cycle's carry
    always_ff @(posedge clk) begin
        if (rst || clr)  sum_q <= '0;
        else if (!hold)  sum_q <= sum_q + opnd + W'(cin);
    end

endmodule

// File: rtl/seg_accum.sv
module seg_accum #(
    parameter int ACC_W = 32,
    parameter int IN_W  = 16,
    parameter int LO_W  = acc_pkg::split_point(ACC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [IN_W-1:0]  in_data,
    output logic [ACC_W-1:0] sum_out,
    output logic             done
);

    localparam int HI_W = ACC_W - LO_W;

    logic             accept;
    logic [ACC_W-1:0] op_q;
    logic [LO_W-1:0]  lo_sum;
    logic [HI_W-1:0]  hi_sum;
    logic             cut_carry;

    acc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .in_valid (in_valid),
        .in_last  (in_last),
        .accept   (accept),
        .done     (done)
    );

    acc_in_buf #(.IN_W(IN_W), .ACC_W(ACC_W)) u_in_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .accept  (accept),
        .in_data (in_data),
        .op_q    (op_q)
    );

    acc_lo_seg #(.W(LO_W)) u_lo (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .hold    (done),
        .opnd    (op_q[LO_W-1:0]),
        .sum_q   (lo_sum),
        .carry_q (cut_carry)
    );

    acc_hi_seg #(.W(HI_W)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .hold  (done),
        .opnd  (op_q[ACC_W-1:LO_W]),
        .cin   (cut_carry),
        .sum_q (hi_sum)
    );

    assign sum_out = {hi_sum, lo_sum};

    // R3: a finished stream leaves no carry pending at the cut
    assert_no_pending_carry_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !cut_carry);

    // R6: clear empties the accumulator and drops done
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum_out == '0 && !done));

    // R7: the frozen sum is not disturbed by further input
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> ($stable(sum_out) && done));

endmodule

// File: tb/seg_accum_bench.sv
module seg_accum_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [15:0] in_data = '0;
    logic [31:0] sum32;
    logic [26:0] sum27;
    logic        done32, done27;

    int checks = 0;
    int failures = 0;
    bit reported = 1'b0;
    longint expv;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    seg_accum u_seg_accum (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .sum_out(sum32), .done(done32)
    );

    seg_accum #(.ACC_W(27), .IN_W(16)) u_seg_accum_w27 (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .sum_out(sum27), .done(done27)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // called at a negedge; returns one negedge later
    task automatic push(input logic [15:0] v, input logic last);
        in_valid = 1'b1;
        in_last  = last;
        in_data  = v;
        expv     = expv + longint'($signed(v));
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        expv = 0;
    endtask

    // after push of the last operand: done timing and final sums
    task automatic finish_stream(input string req);
        @(negedge clk);
        check({req, " R4 done low after edge k+1"}, {63'd0, done32}, 64'd0);
        @(negedge clk);
        check({req, " R4 done high after edge k+2"}, {63'd0, done32}, 64'd1);
        check({req, " R9 done high w27"}, {63'd0, done27}, 64'd1);
        check({req, " R3 sum32"}, {32'd0, sum32}, {32'd0, expv[31:0]});
        check({req, " R9 sum27"}, {37'd0, sum27}, {37'd0, expv[26:0]});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 sum in reset", {32'd0, sum32}, 64'd0);
        check("R1 done in reset", {63'd0, done32}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sum after reset", {32'd0, sum32}, 64'd0);
        check("R1 done after reset", {63'd0, done32 | done27}, 64'd0);
    endtask

    task automatic t_positive();
        clear();
        push(16'd1, 1'b0); push(16'd2, 1'b0); push(16'd3, 1'b0); push(16'd4, 1'b1);
        finish_stream("R3 positive");
        check("R3 positive literal", {32'd0, sum32}, 64'd10);
    endtask

    task automatic t_negative();
        clear();
        push(-16'sd5, 1'b0); push(16'd3, 1'b0); push(-16'sd100, 1'b1);
        finish_stream("R2 negative");
        check("R2 sign extended literal", {32'd0, sum32}, {32'd0, 32'hFFFF_FF9A});
    endtask

    task automatic t_carry();
        clear();
        push(16'hFFFF, 1'b0); push(16'h0001, 1'b1);
        @(negedge clk);
        check("R5 deferred carry visible 32", {32'd0, sum32}, {32'd0, 32'hFFFF_0000});
        check("R5 deferred carry visible 27", {37'd0, sum27}, {37'd0, 27'h7FF_E000});
        check("R5 done low mid flush", {63'd0, done32}, 64'd0);
        @(negedge clk);
        check("R5 flushed sum 32", {32'd0, sum32}, 64'd0);
        check("R5 flushed sum 27", {37'd0, sum27}, 64'd0);
        check("R5 done", {63'd0, done32}, 64'd1);
    endtask

    task automatic t_gaps();
        clear();
        push(16'd300, 1'b0);
        repeat (3) @(negedge clk);
        push(-16'sd7, 1'b0);
        @(negedge clk);
        push(16'h7FFF, 1'b0);
        repeat (2) @(negedge clk);
        push(16'd9, 1'b1);
        finish_stream("R8 gaps");
    endtask

    task automatic t_hold();
        logic [31:0] frozen;
        clear();
        push(16'd40, 1'b0); push(16'd2, 1'b1);
        finish_stream("R7 setup");
        frozen = sum32;
        in_valid = 1'b1; in_data = 16'd55;
        repeat (3) @(negedge clk);
        in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 sum unchanged by input", {32'd0, sum32}, {32'd0, frozen});
        check("R7 done held", {63'd0, done32}, 64'd1);
    endtask

    task automatic t_clear_carry();
        clear();
        push(16'hFFFF, 1'b0); push(16'h0001, 1'b0);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        expv = 0;
        check("R6 sum cleared", {32'd0, sum32}, 64'd0);
        check("R6 done cleared", {63'd0, done32}, 64'd0);
        push(16'd7, 1'b1);
        finish_stream("R6 no carry leak");
    endtask

    task automatic t_clr_priority();
        clr = 1'b1; in_valid = 1'b1; in_data = 16'd9;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        expv = 0;
        push(16'd1, 1'b1);
        finish_stream("R10 operand with clear dropped");
        check("R10 literal", {32'd0, sum32}, 64'd1);
    endtask

    task automatic t_long();
        clear();
        for (int i = 0; i < 5000; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            push((i % 3 == 2) ? lcg[30:15] : {1'b0, lcg[29:15]}, i == 4999);
        end
        finish_stream("R9 long stream");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        expv = 0;
        @(negedge clk);
        t_reset();
        t_positive();
        t_negative();
        t_carry();
        t_gaps();
        t_hold();
        t_clear_carry();
        t_clr_priority();
        t_long();
        report();
    end

endmodule